// File: doc/BRIEF.md
# Over-Temperature Shutdown Guard

This block protects a power stage from overheating. Two comparator flags arrive from an external temperature sensor: one says the die is above the trip threshold, the other says it has cooled below the lower recovery threshold. The block turns these into a shutdown command for the converter and regulators, and an over-temperature status bit. The gap between the two thresholds gives hysteresis: the shutdown starts at the upper threshold, and operation resumes only at the lower one.

Each new entry into shutdown is counted. When the count reaches a limit (four by default), the block latches the device off. It then raises a latched-fault bit and pulls an active-low fault pin low. Cooling does not end this state. Only a power-on reset, or a low period on the global enable bit, clears the latch and the counter. The comparator flags are synchronised inside the block. The enable bit and the reset come from the chip's own clock domain.

Top module: `thermGuard`

## Requirements
- R1: While the active-low power-on reset `rstN` is asserted, `shutdown`=1, `otStatus`=0, `latchedFault`=0 and `faultN`=1.
- R2: When enabled, cool and not latched, `shutdown` is 0.
- R3: When `overTemp` rises while enabled, `shutdown` and `otStatus` both go to 1 exactly SYNC_STAGES+1 clock edges later.
- R4: After the over-temperature condition is recorded, dropping `overTemp` alone keeps `shutdown` and `otStatus` at 1. Both clear only once `underRecover` is 1 while `overTemp` is 0.
- R5: When `overTemp` and `underRecover` are both 1, `overTemp` wins: the block enters or stays in shutdown.
- R6: The shutdown-event counter increments once for each rising entry into the over-temperature state, however long that state lasts. It saturates at EVENT_LIMIT.
- R7: On the EVENT_LIMIT-th entry (the fourth by default), `latchedFault` goes to 1 and `faultN` goes to 0. This happens on the same edge that `otStatus` rises.
- R8: While latched and enabled, `shutdown` stays 1 and `latchedFault` stays 1, even after cooling below the recovery threshold and through further heating events. `otStatus` still follows the hysteresis.
- R9: One edge after `enable` goes low, `shutdown`=1, `otStatus`=0, `latchedFault`=0 and `faultN`=1. While `enable` is low, the counter is held at zero. After `enable` returns high, EVENT_LIMIT fresh events are needed to latch again.
- R10: A power-on reset clears the latch and the counter. After release, a cool enabled device runs, and fewer than EVENT_LIMIT events do not latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| enable | input | 1 | Global enable bit; a low period clears the latch |
| overTemp | input | 1 | Comparator flag: above the trip threshold (asynchronous) |
| underRecover | input | 1 | Comparator flag: below the recovery threshold (asynchronous) |
| shutdown | output | 1 | Command to switch off converter and regulators |
| otStatus | output | 1 | Over-temperature status bit |
| latchedFault | output | 1 | Latched-off status bit |
| faultN | output | 1 | Active-low fault pin |

## Verification
The hardest state to reach from the ports is the boundary between the last unlatched event and the latching one. The counter is not visible, so the only evidence of its value is whether a later event latches. The stimulus first holds one heating event for many cycles and then counts short events up to the limit. A bench that miscounted by cycle, or a design that did so, would latch early. The same count-up is repeated after an enable toggle and after a power-on reset, to show that the counter really restarted.

// File: rtl/thermGuardPkg.sv
package thermGuardPkg;

  // Strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic hotSet;    // enter the over-temperature state
    logic hotClr;    // leave the over-temperature state
    logic cntInc;    // count one shutdown event
    logic latchSet;  // latch the device off
    logic clrAll;    // enable low: clear everything, force shutdown
  } guardStrobes_t;

  // State the datapath reports back to control
  typedef struct packed {
    logic hot;
    logic cntFull;
    logic cntAtLast;
    logic latched;
  } guardStatus_t;

endpackage

// File: rtl/flagSync.sv
module flagSync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign syncOut = asyncIn;
    end else begin : g_chain
      logic [WIDTH-1:0] stage [STAGES];
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
          always_ff @(posedge clk or negedge rstN) begin
            if (!rstN) stage[0] <= '0;
            else       stage[0] <= asyncIn;
          end
        end else begin : g_next
          always_ff @(posedge clk or negedge rstN) begin
            if (!rstN) stage[i] <= '0;
            else       stage[i] <= stage[i-1];
          end
        end
      end
      assign syncOut = stage[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/thermGuardCtrl.sv
module thermGuardCtrl
  import thermGuardPkg::*;
(
  input  logic          enable,
  input  logic          hotFlag,
  input  logic          coolFlag,
  input  guardStatus_t  status,
  output guardStrobes_t strobes
);

  always_comb begin
    strobes        = '0;
    strobes.clrAll = !enable;
    if (enable) begin
      // The trip flag wins over the recovery flag
      strobes.hotSet   = hotFlag && !status.hot;
      strobes.hotClr   = status.hot && !hotFlag && coolFlag;
      // One count per rising entry; stop at the limit
      strobes.cntInc   = strobes.hotSet && !status.cntFull;
      strobes.latchSet = strobes.cntInc && status.cntAtLast;
    end
  end

endmodule

// File: rtl/thermGuardPath.sv
module thermGuardPath
  import thermGuardPkg::*;
#(
  parameter int EVENT_LIMIT = 4,
  parameter int CNT_W       = $clog2(EVENT_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  guardStrobes_t    strobes,
  output guardStatus_t     status,
  output logic             shutdown,
  output logic             otStatus,
  output logic             latchedFault,
  output logic             faultN,
  output logic [CNT_W-1:0] eventCount
);

  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(EVENT_LIMIT);
  localparam logic [CNT_W-1:0] LAST_V  = CNT_W'(EVENT_LIMIT - 1);

  logic             hotQ, hotD;
  logic             latchedQ, latchedD;
  logic             shutdownQ, shutdownD;
  logic [CNT_W-1:0] countQ, countD;

  always_comb begin
    hotD     = hotQ;
    latchedD = latchedQ;
    countD   = countQ;
    if (strobes.clrAll) begin
      hotD     = 1'b0;
      latchedD = 1'b0;
      countD   = '0;
    end else begin
      if (strobes.hotSet)      hotD = 1'b1;
      else if (strobes.hotClr) hotD = 1'b0;
      if (strobes.cntInc)   countD   = countQ + 1'b1;
      if (strobes.latchSet) latchedD = 1'b1;
    end
    shutdownD = strobes.clrAll || hotD || latchedD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hotQ      <= 1'b0;
      latchedQ  <= 1'b0;
      shutdownQ <= 1'b1;
      countQ    <= '0;
    end else begin
      hotQ      <= hotD;
      latchedQ  <= latchedD;
      shutdownQ <= shutdownD;
      countQ    <= countD;
    end
  end

  assign status.hot       = hotQ;
  assign status.cntFull   = (countQ == LIMIT_V);
  assign status.cntAtLast = (countQ == LAST_V);
  assign status.latched   = latchedQ;

  assign shutdown     = shutdownQ;
  assign otStatus     = hotQ;
  assign latchedFault = latchedQ;
  assign faultN       = ~latchedQ;
  assign eventCount   = countQ;

endmodule

// File: rtl/thermGuard.sv
module thermGuard
  import thermGuardPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int EVENT_LIMIT = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic overTemp,
  input  logic underRecover,
  output logic shutdown,
  output logic otStatus,
  output logic latchedFault,
  output logic faultN
);

  localparam int CNT_W = $clog2(EVENT_LIMIT + 1);

  logic [1:0]       flagsSync;
  guardStrobes_t    strobes;
  guardStatus_t     status;
  logic [CNT_W-1:0] eventCount;

  flagSync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({overTemp, underRecover}),
    .syncOut (flagsSync)
  );

  thermGuardCtrl u_ctrl (
    .enable   (enable),
    .hotFlag  (flagsSync[1]),
    .coolFlag (flagsSync[0]),
    .status   (status),
    .strobes  (strobes)
  );

  thermGuardPath #(.EVENT_LIMIT(EVENT_LIMIT), .CNT_W(CNT_W)) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .status       (status),
    .shutdown     (shutdown),
    .otStatus     (otStatus),
    .latchedFault (latchedFault),
    .faultN       (faultN),
    .eventCount   (eventCount)
  );

endmodule

// File: rtl/thermGuardChecker.sv
module thermGuardChecker #(
  parameter int EVENT_LIMIT = 4,
  parameter int CNT_W       = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             shutdown,
  input logic             otStatus,
  input logic             latchedFault,
  input logic             faultN,
  input logic [CNT_W-1:0] eventCount
);

  assert_hot_shuts_R3: assert property (@(posedge clk) disable iff (!rstN)
    otStatus |-> shutdown);

  assert_count_sat_R6: assert property (@(posedge clk) disable iff (!rstN)
    eventCount <= CNT_W'(EVENT_LIMIT));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> (eventCount == $past(eventCount) ||
                eventCount == $past(eventCount) + 1'b1));

  assert_latch_with_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latchedFault) |-> ($rose(otStatus) && $fell(faultN)));

  assert_latch_shuts_R8: assert property (@(posedge clk) disable iff (!rstN)
    latchedFault |-> shutdown);

  assert_latch_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (latchedFault && enable) |=> latchedFault);

  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (shutdown && !otStatus && !latchedFault && eventCount == '0));

endmodule

bind thermGuard thermGuardChecker #(.EVENT_LIMIT(EVENT_LIMIT), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .enable       (enable),
  .shutdown     (shutdown),
  .otStatus     (otStatus),
  .latchedFault (latchedFault),
  .faultN       (faultN),
  .eventCount   (eventCount)
);

// File: tb/test_thermGuard.sv
module test_thermGuard;

  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;

  logic clk = 1'b0;
  logic rstN, enable, overTemp, underRecover;
  logic shutdown, otStatus, latchedFault, faultN;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  thermGuard #(.SYNC_STAGES(SYNC), .EVENT_LIMIT(4)) i_thermGuard (
    .clk, .rstN, .enable, .overTemp, .underRecover,
    .shutdown, .otStatus, .latchedFault, .faultN
  );

  // {enable, overTemp, underRecover} {shutdown, otStatus, latchedFault, faultN} {req}
  localparam int NV = 17;
  localparam logic [10:0] VEC [NV] = '{
    {3'b101, 4'b0001, 4'd2},  // R2 enabled and cool: running
    {3'b110, 4'b1101, 4'd3},  // R3 trip, event 1
    {3'b100, 4'b1101, 4'd4},  // R4 inside hysteresis band: stay off
    {3'b101, 4'b0001, 4'd4},  // R4 recovered
    {3'b111, 4'b1101, 4'd5},  // R5 both flags: trip wins, event 2
    {3'b110, 4'b1101, 4'd6},  // R6 still hot, no new count
    {3'b101, 4'b0001, 4'd6},
    {3'b110, 4'b1101, 4'd6},  // R6 event 3, not latched
    {3'b101, 4'b0001, 4'd6},
    {3'b110, 4'b1110, 4'd7},  // R7 event 4 latches
    {3'b101, 4'b1010, 4'd8},  // R8 cooled but latched off
    {3'b110, 4'b1110, 4'd8},  // R8 further event, saturated
    {3'b101, 4'b1010, 4'd8},
    {3'b001, 4'b1001, 4'd9},  // R9 enable low clears latch
    {3'b101, 4'b0001, 4'd9},  // R9 re-enabled runs
    {3'b110, 4'b1101, 4'd9},  // R9 count restarted: event 1 only
    {3'b010, 4'b1001, 4'd9}   // R9 disabled while hot: status low
  };

  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] got;
    got = {shutdown, otStatus, latchedFault, faultN};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: sd/ot/lat/fN actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic drive(input logic e, input logic o, input logic u);
    @(negedge clk);
    enable = e; overTemp = o; underRecover = u;
    repeat (LAT) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; overTemp = 1'b0; underRecover = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset state", 4'b1001);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][10], VEC[i][9], VEC[i][8]);
      chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][7:4]);
    end

    // R9: enable takes effect after exactly one edge
    drive(1'b0, 1'b0, 1'b1);
    enable = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9 enable rise latency", 4'b0001);
    enable = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R9 enable fall latency", 4'b1001);

    // R3: exact trip latency (not one edge early)
    drive(1'b1, 1'b0, 1'b1);
    overTemp = 1'b1; underRecover = 1'b0;
    repeat (LAT - 1) @(posedge clk); @(negedge clk);
    chk("R3 not yet tripped", 4'b0001);
    @(posedge clk); @(negedge clk);
    chk("R3 tripped on time", 4'b1101);
    drive(1'b1, 1'b0, 1'b1);
    // events 2..4 latch
    for (int k = 2; k <= 4; k++) begin
      drive(1'b1, 1'b1, 1'b0);
      drive(1'b1, 1'b0, 1'b1);
    end
    chk("R8 latched after count", 4'b1010);

    // R10: power-on reset clears latch and count
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    chk("R10 reset while latched", 4'b1001);
    rstN = 1'b1;
    drive(1'b1, 1'b0, 1'b1);
    chk("R10 runs after reset", 4'b0001);

    // R6: one long hot period counts once
    @(negedge clk); overTemp = 1'b1; underRecover = 1'b0;
    repeat (50) @(posedge clk); @(negedge clk);
    chk("R6 long hot period", 4'b1101);
    drive(1'b1, 1'b0, 1'b1);
    for (int k = 2; k <= 3; k++) begin
      drive(1'b1, 1'b1, 1'b0);
      chk($sformatf("R10 event %0d no latch", k), 4'b1101);
      drive(1'b1, 1'b0, 1'b1);
    end
    chk("R6 three events still running", 4'b0001);
    drive(1'b1, 1'b1, 1'b0);
    chk("R7 fourth event latches", 4'b1110);

    summary();
  end

endmodule